// File: doc/BRIEF.md
# Presettable BCD Decade Counter

This block is a four-bit synchronous counter that steps through the decimal digits 0 to 9 in 8421 coding and then returns to 0. On a clock edge it can take a new value from four parallel data inputs. This makes it suitable for programmable frequency dividers, where a stage is preset to a chosen start digit.

Counting needs two enables: a parallel enable and a trickle enable. Both must be high for the counter to advance. The trickle enable also qualifies the terminal-count flag. Several digits can therefore be chained into a synchronous multi-digit counter. Every stage shares the clock and the parallel enable. Each stage's trickle enable is driven from the terminal count of the stage below it.

The clear input is active low. A build-time parameter makes it either asynchronous, where it acts at once with no clock edge, or synchronous, where it acts on the next rising edge. In both modes the clear wins over loading and counting.

Top module: `bcd_decade_counter`

## Requirements
- R1: With both count enables high, no clear and no load, each rising edge moves the value from n to n+1 for n in 0..8, and from 9 to 0.
- R2: With no clear and no load, if either count enable is low, the value does not change across a rising edge.
- R3: When load_n is low (active low) and no clear is active, the next rising edge copies din into q, whatever the count enables are.
- R4: With RESET_SYNC=0, a low rst_n drives q to 0 at once, without waiting for a clock edge, and keeps it at 0 while rst_n stays low.
- R5: With RESET_SYNC=1, a low rst_n leaves q unchanged until the next rising edge. That edge sets q to 0 even when a load or a count is requested at the same time.
- R6: tc is high exactly when en_trk is high and q equals 9. The value of en_par has no effect on tc.
- R7: A loaded value in 10..15 advances in plain binary (15 wraps to 0) when counting is enabled, and tc stays low for all such values.
- R8: Two stages on a common clock form a 00..99 counter. The lower stage has both enables high. The upper stage has en_par high and en_trk driven by the lower stage's tc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes except the asynchronous clear happen on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to RESET_SYNC |
| load_n | input | 1 | Active-low parallel load request |
| din | input | 4 | Parallel load value |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also qualifies tc |
| q | output | 4 | Counter value |
| tc | output | 1 | Terminal count flag |

## Verification
The bench drives the 9-to-0 wrap. A counter that ran on to 10 would show up there, and so would a two-stage chain that skipped or repeated a decade. It pulls rst_n low in the middle of a clock period on an asynchronous instance and on a synchronous instance side by side. A clear with the wrong timing either leaves q nonzero before the edge or clears it too early. The bench also asserts load and clear together, and load together with active enables, so a wrong priority order loads data or counts when it should not. It holds q at 9 with en_par low to expose a tc that wrongly depends on the parallel enable. It loads 13 to check the binary run through 15 back to 0 with tc held low.

// File: rtl/bcd_cnt_pkg.sv
`timescale 1ns/1ps
package bcd_cnt_pkg;

  localparam int DIGIT_W   = 4;
  localparam int DIGIT_TOP = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } act_e;

  // Successor of a digit: decade wrap at the top BCD value, plain binary
  // (with natural 4-bit wrap) for every other value, including 10..15.
  function automatic digit_t digit_succ(digit_t v);
    if (v == digit_t'(DIGIT_TOP)) return '0;
    return v + digit_t'(1);
  endfunction

  function automatic logic is_top(digit_t v);
    return v == digit_t'(DIGIT_TOP);
  endfunction

endpackage

// File: rtl/bcd_action_sel.sv
`timescale 1ns/1ps
module bcd_action_sel
  import bcd_cnt_pkg::*;
#(
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic rst_n,
  input  logic load_n,
  input  logic en_par,
  input  logic en_trk,
  output act_e act
);

  logic clr_req;

  generate
    if (RESET_SYNC) begin : g_sync_clr
      assign clr_req = ~rst_n;
    end else begin : g_async_clr
      // The register clears itself through its asynchronous input.
      assign clr_req = 1'b0;
    end
  endgenerate

  always_comb begin
    if (clr_req)                act = ACT_CLEAR;
    else if (!load_n)           act = ACT_LOAD;
    else if (en_par && en_trk)  act = ACT_COUNT;
    else                        act = ACT_HOLD;
  end

endmodule

// File: rtl/bcd_next_mux.sv
`timescale 1ns/1ps
module bcd_next_mux
  import bcd_cnt_pkg::*;
(
  input  act_e   act,
  input  digit_t cur,
  input  digit_t din,
  output digit_t nxt
);

  always_comb begin
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = din;
      ACT_COUNT: nxt = digit_succ(cur);
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/bcd_digit_reg.sv
`timescale 1ns/1ps
module bcd_digit_reg
  import bcd_cnt_pkg::*;
#(
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  digit_t d,
  output digit_t q
);

  generate
    if (RESET_SYNC) begin : g_sync
      // The clear arrives through d from the action selector.
      always_ff @(posedge clk) q <= d;
    end else begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/bcd_decade_counter.sv
`timescale 1ns/1ps
module bcd_decade_counter
  import bcd_cnt_pkg::*;
#(
  parameter bit RESET_SYNC = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_n,
  input  logic [3:0] din,
  input  logic       en_par,
  input  logic       en_trk,
  output logic [3:0] q,
  output logic       tc
);

  act_e   act;
  digit_t nxt;
  digit_t cur;

  // Named events for the checker.
  logic cnt_fire;
  logic load_fire;

  bcd_action_sel #(.RESET_SYNC(RESET_SYNC)) u_sel (
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .act    (act)
  );

  bcd_next_mux u_mux (
    .act (act),
    .cur (cur),
    .din (din),
    .nxt (nxt)
  );

  bcd_digit_reg #(.RESET_SYNC(RESET_SYNC)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (cur)
  );

  assign cnt_fire  = (act == ACT_COUNT);
  assign load_fire = (act == ACT_LOAD);
  assign q         = cur;
  assign tc        = en_trk & is_top(cur);

endmodule

// File: rtl/bcd_decade_counter_chk.sv
`timescale 1ns/1ps
module bcd_decade_counter_chk #(
  parameter bit RESET_SYNC = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       load_n,
  input logic [3:0] din,
  input logic       en_par,
  input logic       en_trk,
  input logic [3:0] q,
  input logic       tc,
  input logic       cnt_fire,
  input logic       load_fire
);

  logic [1:0] arm_sr = 2'b00;
  always_ff @(posedge clk) arm_sr <= {arm_sr[0], 1'b1};
  wire armed = arm_sr[1];

  // R1
  wrap_at_nine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && q == 4'd9) |=> (q == 4'd0));

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && q < 4'd9) |=> (q == $past(q) + 4'd1));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (q == $past(din)));

  // R4 R5
  clear_result_chk: assert property (@(posedge clk) disable iff (!armed)
    !rst_n |=> (q == 4'd0));

  // R6
  tc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_trk && q == 4'd9) |-> tc);

  // R6
  tc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (en_trk && q == 4'd9));

  // R7
  tc_low_out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q > 4'd9) |-> !tc);

endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.RESET_SYNC(RESET_SYNC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .din       (din),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .q         (q),
  .tc        (tc),
  .cnt_fire  (cnt_fire),
  .load_fire (load_fire)
);

// File: tb/bcd_decade_counter_test.sv
`timescale 1ns/1ps
module bcd_decade_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [3:0] q_a, q_s;
  logic       tc_a, tc_s;

  logic       c_rst_n = 1'b0;
  logic       c_run = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_decade_counter #(.RESET_SYNC(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q_a), .tc(tc_a));

  bcd_decade_counter #(.RESET_SYNC(1'b1)) uut_sync (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .q(q_s), .tc(tc_s));

  bcd_decade_counter #(.RESET_SYNC(1'b1)) u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_run), .en_trk(c_run), .q(lo_q), .tc(lo_tc));

  bcd_decade_counter #(.RESET_SYNC(1'b1)) u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(1'b1), .din(4'd0),
    .en_par(c_run), .en_trk(lo_tc), .q(hi_q), .tc(hi_tc));

  typedef struct {
    logic [3:0] exp_q;
    logic       exp_tc;
    string      tag;
  } item_t;

  item_t sb[$];
  int    model = 0;

  // Reference successor: decimal roll-over at 9, otherwise modulo-16 step.
  function automatic int ref_next(int v);
    if (v == 9) return 0;
    return (v + 1) % 16;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue the expected result.
  task automatic step(bit r, bit ld, int d, bit ep, bit et, string tag);
    item_t it;
    @(negedge clk);
    rst_n = r; load_n = ld; din = 4'(d); en_par = ep; en_trk = et;
    if (!r)                model = 0;
    else if (!ld)          model = d;
    else if (ep && et)     model = ref_next(model);
    @(posedge clk);
    #1;
    it.exp_q  = 4'(model);
    it.exp_tc = et && (model == 9);
    it.tag    = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare both reset variants against the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1.5;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(q_a == it.exp_q, {it.tag, " q async"}, q_a, it.exp_q);
        check(q_s == it.exp_q, {it.tag, " q sync"}, q_s, it.exp_q);
        check(tc_a == it.exp_tc, {it.tag, " tc async"}, tc_a, it.exp_tc);
        check(tc_s == it.exp_tc, {it.tag, " tc sync"}, tc_s, it.exp_tc);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // Reset state (R4 R5)
    step(0, 1, 0, 1, 1, "R4 reset");
    step(0, 1, 0, 1, 1, "R5 reset");

    // Count through the decade wrap (R1)
    for (int i = 0; i < 12; i++) step(1, 1, 0, 1, 1, "R1 count");

    // Hold with either enable low (R2)
    step(1, 0, 5, 0, 0, "R3 load5");
    step(1, 1, 0, 0, 1, "R2 ep low");
    step(1, 1, 0, 1, 0, "R2 et low");
    step(1, 1, 0, 0, 0, "R2 both low");

    // Load overrides active enables (R3)
    step(1, 0, 7, 1, 1, "R3 load over count");
    step(1, 0, 2, 0, 1, "R3 load enables off");

    // Terminal count independent of en_par (R6)
    step(1, 0, 9, 0, 0, "R6 load9 et low");
    step(1, 1, 0, 0, 1, "R6 ep low et high");
    step(1, 1, 0, 1, 0, "R6 ep high et low");
    step(1, 1, 0, 1, 1, "R6 wrap after tc");

    // Out-of-range values count in binary (R7)
    step(1, 0, 13, 0, 1, "R7 load13");
    step(1, 1, 0, 1, 1, "R7 to14");
    step(1, 1, 0, 1, 1, "R7 to15");
    step(1, 1, 0, 1, 1, "R7 wrap15");
    step(1, 1, 0, 1, 1, "R7 to1");

    // Clear beats a simultaneous load and count (R5)
    step(1, 0, 8, 0, 0, "R3 load8");
    step(0, 0, 6, 1, 1, "R5 clear over load");
    step(1, 0, 4, 0, 0, "R3 load4");

    // Mid-cycle clear: async clears at once, sync waits for the edge (R4 R5)
    @(negedge clk);
    load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check(q_a == 4'd0, "R4 immediate clear", q_a, 0);
    check(q_s == 4'd4, "R5 no clear before edge", q_s, 4);
    @(posedge clk);
    #1;
    model = 0;
    sb.push_back('{exp_q: 4'd0, exp_tc: 1'b0, tag: "R5 clear at edge"});
    step(1, 1, 0, 1, 1, "R1 after clear");

    // Two-stage cascade 00..99 (R8)
    @(negedge clk);
    c_rst_n = 1'b0;
    @(negedge clk);
    c_rst_n = 1'b1; c_run = 1'b1;
    for (int n = 1; n <= 105; n++) begin
      @(posedge clk);
      #1.5;
      check((hi_q * 10 + lo_q) == (n % 100), "R8 cascade",
            hi_q * 10 + lo_q, n % 100);
    end
    @(negedge clk);
    c_run = 1'b0;

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule